// File: doc/BRIEF.md
# Serial Command Operand-Loading Controller

This controller sits between a byte-level serial receiver/transmitter and a wide modular exponentiation engine. Each byte the receiver has checked arrives with a valid strobe and a parity-error flag. When the controller is waiting for a command, a byte is read as a command code. One group of codes picks one of four operand registers: base, modulus, exponent or residue. The bytes that follow are then packed into that register until it is full. Other codes start the engine, stream the latched result back to the host, or re-arm the controller for a fresh operand set.

The operands drive the engine directly. The engine receives a one-cycle start pulse and reports completion with a done level and a wide result bus. The result is captured when done is seen and is sent back one byte at a time through a valid/ready handshake with the transmitter. The operand width is a parameter (default 512 bits, so 64 bytes per operand).

Top module: `opload_ctrl`

## Requirements
- R1: In command wait, an accepted byte of value 0x00, 0x01, 0x02 or 0x03 selects the base, modulus, exponent or residue register. The next NB = OP_W/8 accepted bytes fill that register least-significant byte first: the k-th data byte (k from 0) goes into bits [8k+7:8k].
- R2: Loading ends by itself after the NB-th data byte. The next accepted byte is decoded as a command and leaves the just-filled register untouched.
- R3: A byte received with rx_perr high is discarded in every state. It changes no register, and during loading it does not advance the byte position.
- R4: In command wait, byte 0x04 raises eng_start for exactly one cycle, in the cycle after the byte is accepted. The controller then waits for the engine.
- R5: While it waits for the engine, every byte other than 0x07 is ignored. No start pulse, no operand change and no transmission follow.
- R6: eng_done seen while the controller waits for the engine latches eng_result and returns it to command wait. eng_done at any other time has no effect on the latched result.
- R7: In command wait, byte 0x05 presents the NB result bytes on tx_data least-significant first. tx_valid is high, and each byte is held until a cycle with tx_ready high. tx_valid falls after the last handshake.
- R8: Byte 0x07, in command wait, engine wait or transmission, clears all four operands and the latched result to zero and returns to command wait. It aborts any wait or transmission in progress.
- R9: In command wait, the codes 0x06 and 0x08 to 0xFF are ignored. No register changes and the controller stays in command wait.
- R10: After a synchronous active-low reset all operands and the result are zero, and eng_start and tx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe: rx_data holds a new byte |
| rx_perr | input | 1 | Parity check failed for the current byte |
| tx_data | output | 8 | Result byte offered to the transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Transmitter accepts tx_data in this cycle |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_done | input | 1 | Engine has finished |
| eng_result | input | OP_W | Engine result |
| base_q | output | OP_W | Base operand |
| mod_q | output | OP_W | Modulus operand |
| exp_q | output | OP_W | Exponent operand |
| res_q | output | OP_W | Residue operand |

## Verification
The assertions take two things for granted. First, a byte flagged with a parity error never carries a meaningful command. Second, the engine and transmitter inputs change only between clock edges, so tx_data stability while tx_ready is low holds unless a 0x07 re-arm byte arrives. The stimulus gives rx_valid for one cycle per byte and drives every input on the falling edge. It pulses eng_done only for one cycle, and it sends a re-arm during transmission only in the dedicated abort case. The bench runs with a 32-bit operand (four bytes) so that it can sweep every register, every unknown code and every abort path.

// File: rtl/opl_pkg.sv
// Package: shared state encoding and command codes for the operand-loading
// controller. Assumes an 8-bit serial byte.
package opl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_LOAD = 2'd1,
        ST_BUSY = 2'd2,
        ST_SEND = 2'd3
    } opl_state_t;

    localparam logic [BYTE_W-1:0] CODE_START = 8'h04;
    localparam logic [BYTE_W-1:0] CODE_SEND  = 8'h05;
    localparam logic [BYTE_W-1:0] CODE_REARM = 8'h07;
endpackage

// File: rtl/opl_cmd_fsm.sv
// Command sequencer: decodes command bytes, tracks the byte position during
// operand loading and result transmission, and issues the engine start pulse.
// Assumes rx_valid is a one-cycle strobe per byte and NBYTES >= 2.
module opl_cmd_fsm
    import opl_pkg::*;
#(
    parameter int NBYTES = 64,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_perr,
    input  logic              tx_ready,
    input  logic              eng_done,
    output opl_state_t        state_q,
    output logic [1:0]        sel_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              wr_en,
    output logic              clr,
    output logic              latch,
    output logic              start_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

    logic good;

    // Qualify bytes and derive the one-cycle actions for the datapath.
    always_comb begin
        good  = rx_valid && !rx_perr;
        wr_en = (state_q == ST_LOAD) && good;
        clr   = good && (rx_data == CODE_REARM) && (state_q != ST_LOAD);
        latch = (state_q == ST_BUSY) && eng_done && !clr;
    end

    // State, selected register, byte position and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            sel_q   <= '0;
            idx_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                ST_CMD: begin
                    if (good) begin
                        if (rx_data < 8'h04) begin
                            sel_q   <= rx_data[1:0];
                            idx_q   <= '0;
                            state_q <= ST_LOAD;
                        end else if (rx_data == CODE_START) begin
                            start_q <= 1'b1;
                            state_q <= ST_BUSY;
                        end else if (rx_data == CODE_SEND) begin
                            idx_q   <= '0;
                            state_q <= ST_SEND;
                        end
                    end
                end
                ST_LOAD: begin
                    if (good) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST) state_q <= ST_CMD;
                    end
                end
                ST_BUSY: begin
                    if (clr || eng_done) state_q <= ST_CMD;
                end
                default: begin
                    if (clr) begin
                        state_q <= ST_CMD;
                    end else if (tx_ready) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST) state_q <= ST_CMD;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/opl_operand_bank.sv
// Operand bank: four operand registers, each written one byte at a time at
// the position given by idx. Assumes idx < OP_W/BYTE_W whenever wr_en is high.
module opl_operand_bank
    import opl_pkg::*;
#(
    parameter int OP_W = 512,
    localparam int NBYTES = OP_W / BYTE_W,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 clr,
    input  logic [1:0]           sel,
    input  logic [IDX_W-1:0]     idx,
    input  logic [BYTE_W-1:0]    wr_byte,
    output logic [3:0][OP_W-1:0] opnd_q
);
    for (genvar g = 0; g < 4; g++) begin : g_reg
        // One operand register: cleared on reset or re-arm, byte-written when selected.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                opnd_q[g] <= '0;
            end else if (wr_en && (sel == 2'(g))) begin
                opnd_q[g][int'(idx)*BYTE_W +: BYTE_W] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/opl_result_reg.sv
// Result holder: captures the engine result on latch and selects the byte
// at position idx for the transmitter. Assumes latch and clr are exclusive.
module opl_result_reg
    import opl_pkg::*;
#(
    parameter int OP_W = 512,
    localparam int NBYTES = OP_W / BYTE_W,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic              clr,
    input  logic [OP_W-1:0]   eng_result,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] byte_out
);
    logic [OP_W-1:0] res_q;

    // Hold the latest engine result; cleared on reset or re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) res_q <= '0;
        else if (latch)    res_q <= eng_result;
    end

    // Pick the byte currently offered to the transmitter.
    always_comb byte_out = res_q[int'(idx)*BYTE_W +: BYTE_W];
endmodule

// File: rtl/opload_ctrl.sv
// Top of the operand-loading controller: joins the command sequencer, the
// operand bank and the result holder. Assumes OP_W is a multiple of 8 and at
// least 16.
module opload_ctrl
    import opl_pkg::*;
#(
    parameter int OP_W = 512,
    localparam int NBYTES = OP_W / BYTE_W,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      rx_data,
    input  logic            rx_valid,
    input  logic            rx_perr,
    output logic [7:0]      tx_data,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic            eng_start,
    input  logic            eng_done,
    input  logic [OP_W-1:0] eng_result,
    output logic [OP_W-1:0] base_q,
    output logic [OP_W-1:0] mod_q,
    output logic [OP_W-1:0] exp_q,
    output logic [OP_W-1:0] res_q
);
    opl_state_t           state_q;
    logic [1:0]           sel_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 wr_en, clr, latch;
    logic [3:0][OP_W-1:0] opnd_q;

    opl_cmd_fsm #(.NBYTES(NBYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .tx_ready(tx_ready), .eng_done(eng_done),
        .state_q(state_q), .sel_q(sel_q), .idx_q(idx_q), .wr_en(wr_en),
        .clr(clr), .latch(latch), .start_q(eng_start)
    );

    opl_operand_bank #(.OP_W(OP_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr(clr), .sel(sel_q),
        .idx(idx_q), .wr_byte(rx_data), .opnd_q(opnd_q)
    );

    opl_result_reg #(.OP_W(OP_W)) u_res (
        .clk(clk), .rst_n(rst_n), .latch(latch), .clr(clr),
        .eng_result(eng_result), .idx(idx_q), .byte_out(tx_data)
    );

    // Route the operand registers and the transmit strobe to the ports.
    always_comb begin
        base_q   = opnd_q[0];
        mod_q    = opnd_q[1];
        exp_q    = opnd_q[2];
        res_q    = opnd_q[3];
        tx_valid = (state_q == ST_SEND);
    end
endmodule

// File: rtl/opload_ctrl_chk.sv
// Checker for opload_ctrl, watching its ports only; attached by bind below.
module opload_ctrl_chk #(
    parameter int OP_W = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      rx_data,
    input logic            rx_valid,
    input logic            rx_perr,
    input logic [7:0]      tx_data,
    input logic            tx_valid,
    input logic            tx_ready,
    input logic            eng_start,
    input logic [OP_W-1:0] base_q,
    input logic [OP_W-1:0] mod_q,
    input logic [OP_W-1:0] exp_q,
    input logic [OP_W-1:0] res_q
);
    logic rearm_in;
    always_comb rearm_in = rx_valid && !rx_perr && (rx_data == 8'h07);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R4

    AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(rx_valid && !rx_perr && rx_data == 8'h04)); // R4

    AST_PERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_perr) |=> ($stable(base_q) && $stable(mod_q)
                                   && $stable(exp_q) && $stable(res_q))); // R3

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !rearm_in) |=> (tx_valid && $stable(tx_data))); // R7

    AST_START_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !tx_valid); // R5

    AST_TX_KEEPS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !rearm_in) |=> ($stable(base_q) && $stable(mod_q)
                                     && $stable(exp_q) && $stable(res_q))); // R8
endmodule

bind opload_ctrl opload_ctrl_chk #(.OP_W(OP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .eng_start(eng_start), .base_q(base_q),
    .mod_q(mod_q), .exp_q(exp_q), .res_q(res_q)
);

// File: tb/opload_ctrl_bench.sv
`timescale 1ns/1ps
module opload_ctrl_bench;
    localparam int OPW = 32;
    localparam int NB  = OPW / 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     rx_data = '0;
    logic           rx_valid = 1'b0;
    logic           rx_perr = 1'b0;
    logic [7:0]     tx_data;
    logic           tx_valid;
    logic           tx_ready = 1'b0;
    logic           eng_start;
    logic           eng_done = 1'b0;
    logic [OPW-1:0] eng_result = '0;
    logic [OPW-1:0] base_q, mod_q, exp_q, res_q;

    int   checks = 0;
    int   errors = 0;
    logic start_seen, tx_seen;
    logic [OPW-1:0] exp_op [4];

    always #2 clk = ~clk;

    opload_ctrl #(.OP_W(OPW)) u_opload_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .eng_start(eng_start), .eng_done(eng_done),
        .eng_result(eng_result), .base_q(base_q), .mod_q(mod_q),
        .exp_q(exp_q), .res_q(res_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [OPW-1:0] get_op(input int s);
        case (s)
            0: return base_q;
            1: return mod_q;
            2: return exp_q;
            default: return res_q;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'((s * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic send_byte(input logic [7:0] b, input logic perr);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1; rx_perr = perr;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0;
        start_seen = eng_start;
        tx_seen = tx_valid;
    endtask

    task automatic check_all_ops(input string tag);
        for (int s = 0; s < 4; s++) chk(tag, get_op(s), exp_op[s]);
    endtask

    task automatic pulse_done(input logic [OPW-1:0] r);
        @(negedge clk);
        eng_result = r; eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // Collect NB bytes after a send command, stalling on odd bytes.
    task automatic collect(input logic [OPW-1:0] expv, input string tag);
        for (int k = 0; k < NB; k++) begin
            if (k % 2 == 1) begin
                logic [7:0] held;
                held = tx_data;
                @(negedge clk);
                chk({tag, " R7 hold valid"}, 32'(tx_valid), 32'd1);
                chk({tag, " R7 hold data"}, 32'(tx_data), 32'(held));
            end
            chk({tag, " R7 byte"}, 32'(tx_data), 32'(expv[k*8 +: 8]));
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
        end
        chk({tag, " R7 valid low after last"}, 32'(tx_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) exp_op[s] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check_all_ops("R10 operands zero");
        chk("R10 start low", 32'(eng_start), 32'd0);
        chk("R10 tx_valid low", 32'(tx_valid), 32'd0);
        rst_n = 1'b1;

        // R1, R2, R3: load every register back to back, a parity-error byte in each
        for (int s = 0; s < 4; s++) begin
            send_byte(8'(s), 1'b0);
            for (int k = 0; k < NB; k++) begin
                if (k == 1) begin
                    send_byte(8'hA5, 1'b1);
                    chk("R3 perr byte dropped", get_op(s), exp_op[s]);
                end
                send_byte(pat(s, k), 1'b0);
                exp_op[s][k*8 +: 8] = pat(s, k);
                chk("R1 byte placed", get_op(s), exp_op[s]);
            end
        end
        check_all_ops("R2 load ended, no overwrite");

        // R9: unknown codes ignored in command wait
        for (int c = 6; c < 256; c++) begin
            if (c == 7) continue;
            send_byte(8'(c), 1'b0);
            if (start_seen !== 1'b0 || tx_seen !== 1'b0)
                chk("R9 unknown code no action", {30'd0, start_seen, tx_seen}, 32'd0);
            else checks++;
        end
        check_all_ops("R9 operands kept");

        // R4: start pulse
        send_byte(8'h04, 1'b0);
        chk("R4 start pulse", 32'(start_seen), 32'd1);
        @(negedge clk);
        chk("R4 start one cycle", 32'(eng_start), 32'd0);

        // R5: busy ignores commands
        send_byte(8'h00, 1'b0);
        chk("R5 no load while busy", 32'(tx_seen), 32'd0);
        send_byte(8'h05, 1'b0);
        chk("R5 no send while busy", 32'(tx_seen), 32'd0);
        send_byte(8'h04, 1'b0);
        chk("R5 no restart while busy", 32'(start_seen), 32'd0);
        check_all_ops("R5 operands kept");

        // R6, R7: done latches result, then transmit it
        pulse_done(32'hC3A51E07);
        send_byte(8'h05, 1'b0);
        chk("R6 back in command wait", 32'(tx_seen), 32'd1);
        collect(32'hC3A51E07, "first");

        // R6: done outside the engine wait is ignored
        pulse_done(32'h11223344);
        send_byte(8'h05, 1'b0);
        chk("R6 send again", 32'(tx_seen), 32'd1);
        collect(32'hC3A51E07, "R6 stale done");

        // R8: re-arm clears operands and result
        send_byte(8'h07, 1'b0);
        for (int s = 0; s < 4; s++) exp_op[s] = '0;
        check_all_ops("R8 operands cleared");
        send_byte(8'h05, 1'b0);
        collect(32'h0, "R8 result cleared");

        // R8: re-arm aborts the engine wait
        send_byte(8'h04, 1'b0);
        send_byte(8'h07, 1'b0);
        send_byte(8'h04, 1'b0);
        chk("R8 abort busy then restart", 32'(start_seen), 32'd1);
        pulse_done(32'h89ABCDEF);
        send_byte(8'h05, 1'b0);
        collect(32'h89ABCDEF, "R8 after abort");

        // R8: re-arm aborts a transmission
        send_byte(8'h05, 1'b0);
        chk("R8 send started", 32'(tx_seen), 32'd1);
        send_byte(8'h07, 1'b0);
        chk("R8 send aborted", 32'(tx_seen), 32'd0);
        send_byte(8'h05, 1'b0);
        chk("R8 result zero after abort", 32'(tx_data), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule